// File: doc/BRIEF.md
# Snooping Invalidation Coherence Controller

This block keeps one small private cache coherent with its peers on a shared bus whose operations are split into a request phase and a later response phase. It holds a tag, a data word and a coherence state for each of four direct-mapped lines. The three stable states are invalid, shared (clean, memory current, readable by anyone) and exclusive (dirty, held by this cache alone, the only writable state). Processor reads and writes that hit are answered locally. Misses and writes to shared lines become bus operations. Traffic observed from other caches is snooped, so that local copies are downgraded or invalidated and dirty data is handed out.

While a line waits between the request and the response of its bus operation, it carries an in-progress mark. No new bus operation is launched for that line, and the processor stalls until the operation finishes. Snooped traffic still acts on the stable state of a marked line. The outstanding operation decides where the line ends up. This is safe because a line holds one whole word, so a completing write overwrites all of it.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid and no line is in progress. `cpu_stall`, `cpu_resp_valid`, `bus_req_valid` and `snp_flush_valid` are low, and the first access to any address misses.
- R2: A read whose tag matches a shared or exclusive line produces `cpu_resp_valid` for one cycle, in the cycle after the request is taken, with the stored word. No bus request is made.
- R3: A write whose tag matches an exclusive line stores the word and responds in the cycle after it is taken. No bus request is made, and the line stays exclusive.
- R4: A read miss on a line that is not exclusive issues a read request (command 0) with the requested address. When the response arrives, the line becomes shared with the response word, and the processor gets that word in the following cycle.
- R5: A write miss on a line that is not exclusive issues a read-for-ownership request (command 1). On the response, the line becomes exclusive and holds the write word.
- R6: A write whose tag matches a shared line issues an invalidate (command 2). The line stays shared until the response, then becomes exclusive with the write word. A snooped read during the wait produces no flush.
- R7: A miss on an index whose line is exclusive under another tag first issues a writeback (command 3). The writeback carries the old line address (tag above the 2 index bits) and the old word. The refill request is sent only after the writeback response.
- R8: From the cycle after a miss or upgrade is taken until its response completes, `cpu_stall` is high and at most one bus request is outstanding. A request holds its command and address until granted.
- R9: A snooped read (command 0) to an exclusive line raises `snp_flush_valid` in the next cycle with that line's address and word, and the line becomes shared.
- R10: A snooped read-for-ownership or invalidate (commands 1, 2) to a matching shared or exclusive line makes it invalid. An exclusive line also flushes its word, as in R9.
- R11: A snooped writeback (command 3), a snoop whose tag does not match, and a snooped read to a shared line change nothing. There is no flush, and a later read still hits.
- R12: A snoop that invalidates a line during its pending upgrade does not cancel the upgrade. At the response the line is exclusive with the write word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present, held until response |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 8 | Word address; low 2 bits pick the line |
| cpu_req_wdata | input | 16 | Write word |
| cpu_stall | output | 1 | A bus operation for the current request is in progress |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | 16 | Read word (write word for writes) |
| bus_req_valid | output | 1 | Request phase active |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 writeback |
| bus_req_addr | output | 8 | Request address |
| bus_req_data | output | 16 | Writeback word, zero otherwise |
| bus_gnt | input | 1 | Request phase accepted this cycle |
| bus_rsp_valid | input | 1 | Response phase for the outstanding request |
| bus_rsp_data | input | 16 | Response word for read requests |
| snp_valid | input | 1 | Snooped operation from another cache |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_req_cmd |
| snp_addr | input | 8 | Snooped address |
| snp_flush_valid | output | 1 | Dirty word supplied in answer to a snoop |
| snp_flush_addr | output | 8 | Address of the flushed line |
| snp_flush_data | output | 16 | Flushed word |

## Verification
A hit answers one cycle after the edge that takes it. A bus request appears in the cycle after the request is taken, or after the previous phase's response. The miss answer follows one cycle after the edge that samples `bus_rsp_valid`, and a snoop flush follows one cycle after the snoop edge. The bench holds a behavioural model that advances on the same edge as the design. Every output is compared away from that edge, a half period later, so each result is checked in exactly the cycle it is due. Directed checks then confirm the returned words, the number of bus grants per access, the stall, and the flush contents after each snoop.

// File: rtl/coh_pkg.sv
package coh_pkg;
    parameter int ADDR_W = 8;
    parameter int DATA_W = 16;
    parameter int LINES  = 4;
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2} line_st_e;
    typedef enum logic [1:0] {BC_RD = 2'd0, BC_RDX = 2'd1, BC_INV = 2'd2, BC_WB = 2'd3} bus_cmd_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        line_st_e          st;
        logic [DATA_W-1:0] data;
    } line_t;

    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W];
    endfunction
endpackage

// File: rtl/coh_line.sv
module coh_line import coh_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  line_t            wr_line,
    input  logic             pend_set,
    input  logic             pend_clr,
    input  logic             snp_en,
    input  bus_cmd_e         snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    output line_t            cur,
    output logic             pend,
    output logic             flush_req
);
    logic     snp_match;
    line_st_e snp_st;

    assign snp_match = snp_en && (snp_cmd != BC_WB) && (cur.st != LS_I) && (cur.tag == snp_tag);
    assign flush_req = snp_match && (cur.st == LS_E);

    always_comb begin
        if (snp_cmd == BC_RD) snp_st = (cur.st == LS_E) ? LS_S : cur.st;
        else                  snp_st = LS_I;
    end

    // local update has priority over a snoop on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '{tag: '0, st: LS_I, data: '0};
            pend <= 1'b0;
        end else begin
            if (wr_en)          cur    <= wr_line;
            else if (snp_match) cur.st <= snp_st;
            if (pend_set)       pend   <= 1'b1;
            else if (pend_clr)  pend   <= 1'b0;
        end
    end

    AST_SNOOP_LEAVES_E: assert property (@(posedge clk) disable iff (rst)
        (flush_req && !wr_en) |=> (cur.st != LS_E)); // R9
    AST_SNOOP_KILLS: assert property (@(posedge clk) disable iff (rst)
        (snp_match && snp_cmd != BC_RD && !wr_en) |=> (cur.st == LS_I)); // R10
endmodule

// File: rtl/coh_seq.sv
module coh_seq import coh_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    input  logic              bus_gnt,
    input  logic              bus_rsp_valid,
    input  logic [DATA_W-1:0] bus_rsp_data,
    input  line_t             sel,
    output logic [IDX_W-1:0]  acc_idx,
    output logic              wr_en,
    output line_t             wr_line,
    output logic              pend_set,
    output logic              pend_clr,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    output logic              cpu_stall,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata
);
    typedef enum logic [2:0] {SQ_IDLE, SQ_WB_REQ, SQ_WB_WAIT, SQ_RQ, SQ_RQ_WAIT} sq_e;

    sq_e               fsm, fsm_n;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    bus_cmd_e          cmd_q, cmd_n;
    logic              resp_q, resp_n;
    logic [DATA_W-1:0] rdata_q, rdata_n;
    logic              take, hit;

    assign acc_idx = (fsm == SQ_IDLE) ? idx_of(cpu_req_addr) : idx_of(addr_q);
    assign take    = (fsm == SQ_IDLE) && cpu_req_valid && !resp_q;
    assign hit     = (sel.st != LS_I) && (sel.tag == tag_of(cpu_req_addr));

    always_comb begin
        fsm_n    = fsm;
        cmd_n    = cmd_q;
        resp_n   = 1'b0;
        rdata_n  = rdata_q;
        wr_en    = 1'b0;
        wr_line  = sel;
        pend_set = 1'b0;
        pend_clr = 1'b0;
        unique case (fsm)
            SQ_IDLE: if (take) begin
                if (hit && (!cpu_req_write || sel.st == LS_E)) begin
                    resp_n  = 1'b1;
                    rdata_n = cpu_req_write ? cpu_req_wdata : sel.data;
                    if (cpu_req_write) begin
                        wr_en        = 1'b1;
                        wr_line.data = cpu_req_wdata;
                    end
                end else begin
                    pend_set = 1'b1;
                    if (hit) begin
                        cmd_n = BC_INV;
                        fsm_n = SQ_RQ;
                    end else begin
                        cmd_n = cpu_req_write ? BC_RDX : BC_RD;
                        fsm_n = (sel.st == LS_E) ? SQ_WB_REQ : SQ_RQ;
                    end
                end
            end
            SQ_WB_REQ:  if (bus_gnt) fsm_n = SQ_WB_WAIT;
            SQ_WB_WAIT: if (bus_rsp_valid) begin
                wr_en      = 1'b1;
                wr_line.st = LS_I;
                fsm_n      = SQ_RQ;
            end
            SQ_RQ:      if (bus_gnt) fsm_n = SQ_RQ_WAIT;
            SQ_RQ_WAIT: if (bus_rsp_valid) begin
                wr_en        = 1'b1;
                wr_line.tag  = tag_of(addr_q);
                wr_line.st   = (cmd_q == BC_RD) ? LS_S : LS_E;
                wr_line.data = (cmd_q == BC_RD) ? bus_rsp_data : wdata_q;
                pend_clr     = 1'b1;
                resp_n       = 1'b1;
                rdata_n      = wr_line.data;
                fsm_n        = SQ_IDLE;
            end
            default: fsm_n = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm     <= SQ_IDLE;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            cmd_q   <= BC_RD;
            resp_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            fsm     <= fsm_n;
            cmd_q   <= cmd_n;
            resp_q  <= resp_n;
            rdata_q <= rdata_n;
            if (take) begin
                addr_q  <= cpu_req_addr;
                wr_q    <= cpu_req_write;
                wdata_q <= cpu_req_wdata;
            end
        end
    end

    assign bus_req_valid  = (fsm == SQ_WB_REQ) || (fsm == SQ_RQ);
    assign bus_req_cmd    = (fsm == SQ_WB_REQ) ? BC_WB : cmd_q;
    assign bus_req_addr   = (fsm == SQ_WB_REQ) ? {sel.tag, idx_of(addr_q)} : addr_q;
    assign bus_req_data   = (fsm == SQ_WB_REQ) ? sel.data : '0;
    assign cpu_stall      = (fsm != SQ_IDLE);
    assign cpu_resp_valid = resp_q;
    assign cpu_resp_rdata = rdata_q;

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_resp_valid |=> !cpu_resp_valid); // R2
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && !bus_gnt) |=> (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_cmd))); // R8
    AST_STALL_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> (cpu_stall && !cpu_resp_valid)); // R8
    AST_WRITE_KIND: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && bus_req_cmd != BC_WB) |-> ((bus_req_cmd == BC_RD) == !wr_q)); // R5
endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl import coh_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_stall,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_gnt,
    input  logic              bus_rsp_valid,
    input  logic [DATA_W-1:0] bus_rsp_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush_valid,
    output logic [ADDR_W-1:0] snp_flush_addr,
    output logic [DATA_W-1:0] snp_flush_data
);
    line_t            lines [LINES];
    logic [LINES-1:0] pend_vec;
    logic [LINES-1:0] flush_vec;
    logic [IDX_W-1:0] acc_idx;
    logic [IDX_W-1:0] snp_idx;
    logic             wr_en, pend_set, pend_clr;
    line_t            wr_line;
    line_t            snp_line;

    assign snp_idx  = idx_of(snp_addr);
    assign snp_line = lines[snp_idx];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        coh_line u_line (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_en && (acc_idx == IDX_W'(g))),
            .wr_line   (wr_line),
            .pend_set  (pend_set && (acc_idx == IDX_W'(g))),
            .pend_clr  (pend_clr && (acc_idx == IDX_W'(g))),
            .snp_en    (snp_valid && (snp_idx == IDX_W'(g))),
            .snp_cmd   (bus_cmd_e'(snp_cmd)),
            .snp_tag   (tag_of(snp_addr)),
            .cur       (lines[g]),
            .pend      (pend_vec[g]),
            .flush_req (flush_vec[g])
        );
    end

    coh_seq u_seq (
        .clk            (clk),
        .rst            (rst),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_write  (cpu_req_write),
        .cpu_req_addr   (cpu_req_addr),
        .cpu_req_wdata  (cpu_req_wdata),
        .bus_gnt        (bus_gnt),
        .bus_rsp_valid  (bus_rsp_valid),
        .bus_rsp_data   (bus_rsp_data),
        .sel            (lines[acc_idx]),
        .acc_idx        (acc_idx),
        .wr_en          (wr_en),
        .wr_line        (wr_line),
        .pend_set       (pend_set),
        .pend_clr       (pend_clr),
        .bus_req_valid  (bus_req_valid),
        .bus_req_cmd    (bus_req_cmd),
        .bus_req_addr   (bus_req_addr),
        .bus_req_data   (bus_req_data),
        .cpu_stall      (cpu_stall),
        .cpu_resp_valid (cpu_resp_valid),
        .cpu_resp_rdata (cpu_resp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            snp_flush_valid <= 1'b0;
            snp_flush_addr  <= '0;
            snp_flush_data  <= '0;
        end else begin
            snp_flush_valid <= |flush_vec;
            snp_flush_addr  <= {snp_line.tag, snp_idx};
            snp_flush_data  <= snp_line.data;
        end
    end

    AST_ONE_PENDING: assert property (@(posedge clk) disable iff (rst)
        $countones(pend_vec) <= 1); // R8
    AST_REQ_MARKED: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> pend_vec[idx_of(bus_req_addr)]); // R8
    AST_IDLE_UNMARKED: assert property (@(posedge clk) disable iff (rst)
        cpu_resp_valid |-> (pend_vec == '0)); // R8
endmodule

// File: tb/coh_snoop_ctrl_tb.sv
module coh_snoop_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_req_valid = 0, cpu_req_write = 0;
    logic [7:0] cpu_req_addr = 0;
    logic [15:0] cpu_req_wdata = 0;
    logic cpu_stall, cpu_resp_valid;
    logic [15:0] cpu_resp_rdata;
    logic bus_req_valid;
    logic [1:0] bus_req_cmd;
    logic [7:0] bus_req_addr;
    logic [15:0] bus_req_data;
    logic bus_gnt = 0, bus_rsp_valid = 0;
    logic [15:0] bus_rsp_data = 0;
    logic snp_valid = 0;
    logic [1:0] snp_cmd = 0;
    logic [7:0] snp_addr = 0;
    logic snp_flush_valid;
    logic [7:0] snp_flush_addr;
    logic [15:0] snp_flush_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    coh_snoop_ctrl u_dut (.*);

    int n_chk = 0, n_bad = 0, cycles = 0, n_gnt = 0;

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // bench memory
    logic [15:0] mem [int];
    function automatic logic [15:0] memval(input logic [7:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return {a, ~a} ^ 16'h5a3c;
    endfunction

    // reference model
    int m_st [4];
    logic [5:0] m_tg [4];
    logic [15:0] m_dt [4];
    int m_ph, m_cmd;
    logic [7:0] m_ad;
    bit m_wr, m_rv, m_fv;
    logic [15:0] m_wd, m_rd, m_fd;
    logic [7:0] m_fa;
    string m_tag = "R1";

    always @(posedge clk) begin : model
        int si, ci, sst, cst;
        bit sdo, cw, hit, nrv, nfv;
        logic [5:0] ctg;
        logic [15:0] cdt, nrd, nfd;
        logic [7:0] nfa;
        if (rst) begin
            for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tg[i] = 0; m_dt[i] = 0; end
            m_ph = 0; m_cmd = 0; m_ad = 0; m_wr = 0; m_wd = 0;
            m_rv = 0; m_rd = 0; m_fv = 0; m_fa = 0; m_fd = 0;
        end else begin
            sdo = 0; cw = 0; nrv = 0; nrd = m_rd; nfv = 0; nfa = m_fa; nfd = m_fd;
            si = int'(snp_addr[1:0]); sst = 0; cst = 0; ctg = 0; cdt = 0;
            if (snp_valid && snp_cmd != 2'd3 && m_st[si] != 0 && m_tg[si] == snp_addr[7:2]) begin
                sdo = 1;
                if (m_st[si] == 2) begin nfv = 1; end
                sst = (snp_cmd == 2'd0) ? ((m_st[si] == 2) ? 1 : m_st[si]) : 0;
            end
            nfa = {m_tg[si], snp_addr[1:0]};
            nfd = m_dt[si];
            ci = (m_ph == 0) ? int'(cpu_req_addr[1:0]) : int'(m_ad[1:0]);
            case (m_ph)
                0: if (cpu_req_valid && !m_rv) begin
                    m_ad = cpu_req_addr; m_wr = cpu_req_write; m_wd = cpu_req_wdata;
                    hit = (m_st[ci] != 0) && (m_tg[ci] == cpu_req_addr[7:2]);
                    if (hit && (!m_wr || m_st[ci] == 2)) begin
                        nrv = 1; nrd = m_wr ? m_wd : m_dt[ci];
                        if (m_wr) begin cw = 1; ctg = m_tg[ci]; cst = 2; cdt = m_wd; end
                        m_tag = m_wr ? "R3" : "R2";
                    end else if (hit) begin
                        m_cmd = 2; m_ph = 3; m_tag = "R6";
                    end else begin
                        m_cmd = m_wr ? 1 : 0;
                        m_ph = (m_st[ci] == 2) ? 1 : 3;
                        m_tag = (m_st[ci] == 2) ? "R7" : (m_wr ? "R5" : "R4");
                    end
                end
                1: if (bus_gnt) m_ph = 2;
                2: if (bus_rsp_valid) begin cw = 1; ctg = m_tg[ci]; cst = 0; cdt = m_dt[ci]; m_ph = 3; end
                3: if (bus_gnt) m_ph = 4;
                4: if (bus_rsp_valid) begin
                    cw = 1; ctg = m_ad[7:2]; cst = (m_cmd == 0) ? 1 : 2;
                    cdt = (m_cmd == 0) ? bus_rsp_data : m_wd;
                    nrv = 1; nrd = cdt; m_ph = 0;
                end
                default: m_ph = 0;
            endcase
            if (sdo && !(cw && ci == si)) m_st[si] = sst;
            if (cw) begin m_st[ci] = cst; m_tg[ci] = ctg; m_dt[ci] = cdt; end
            m_rv = nrv; m_rd = nrd; m_fv = nfv; m_fa = nfa; m_fd = nfd;
        end
    end

    // per-cycle comparison, bus agent and watchdog
    int ag = 0, acnt = 0;
    logic [7:0] aaddr;
    always @(negedge clk) begin : cmp_and_bus
        logic [26:0] eb, ab;
        logic [16:0] er, ar;
        logic [24:0] ef, af;
        int mi;
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL R8 watchdog actual=%0d expected=<100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
        if (!rst) begin
            mi = int'(m_ad[1:0]);
            eb = (m_ph == 1) ? {1'b1, 2'd3, m_tg[mi], m_ad[1:0], m_dt[mi]} :
                 (m_ph == 3) ? {1'b1, 2'(m_cmd), m_ad, 16'h0} : 27'h0;
            ab = bus_req_valid ? {1'b1, bus_req_cmd, bus_req_addr, bus_req_data} : 27'h0;
            chk(ab == eb, m_tag, 32'(ab), 32'(eb));
            er = m_rv ? {1'b1, m_rd} : 17'h0;
            ar = cpu_resp_valid ? {1'b1, cpu_resp_rdata} : 17'h0;
            chk(ar == er, m_tag, 32'(ar), 32'(er));
            chk(cpu_stall == (m_ph != 0), "R8", 32'(cpu_stall), 32'(m_ph != 0));
            ef = m_fv ? {1'b1, m_fa, m_fd} : 25'h0;
            af = snp_flush_valid ? {1'b1, snp_flush_addr, snp_flush_data} : 25'h0;
            chk(af == ef, "R9", 32'(af), 32'(ef));
            if (snp_flush_valid) mem[int'(snp_flush_addr)] = snp_flush_data;
            case (ag)
                0: if (bus_req_valid) begin
                    bus_gnt = 1; aaddr = bus_req_addr; n_gnt++;
                    if (bus_req_cmd == 2'd3) mem[int'(bus_req_addr)] = bus_req_data;
                    ag = 1;
                end
                1: begin bus_gnt = 0; acnt = 1 + int'(aaddr) % 3; ag = 2; end
                2: begin
                    acnt--;
                    if (acnt == 0) begin bus_rsp_valid = 1; bus_rsp_data = memval(aaddr); ag = 3; end
                end
                default: begin bus_rsp_valid = 0; ag = 0; end
            endcase
        end
    end

    task automatic cpu_op(input bit wr, input logic [7:0] a, input logic [15:0] wd,
                          input logic [15:0] exp_rd, input int exp_req, input string r);
        int g0, stl, t;
        logic [15:0] got;
        @(negedge clk);
        g0 = n_gnt; stl = 0; t = 0;
        cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
        do begin
            @(negedge clk);
            t++;
            if (cpu_stall) stl++;
        end while (!cpu_resp_valid && t < 200);
        got = cpu_resp_rdata;
        cpu_req_valid = 0;
        chk(cpu_resp_valid, r, 32'(cpu_resp_valid), 32'd1);
        if (!wr) chk(got == exp_rd, r, 32'(got), 32'(exp_rd));
        chk(n_gnt - g0 == exp_req, r, 32'(n_gnt - g0), 32'(exp_req));
        chk((stl != 0) == (exp_req != 0), "R8", 32'(stl), 32'(exp_req));
    endtask

    task automatic snoop(input logic [1:0] c, input logic [7:0] a, input bit exp_fl,
                         input logic [15:0] exp_d, input string r);
        @(negedge clk);
        snp_valid = 1; snp_cmd = c; snp_addr = a;
        @(negedge clk);
        snp_valid = 0;
        chk(snp_flush_valid == exp_fl, r, 32'(snp_flush_valid), 32'(exp_fl));
        if (exp_fl) chk({snp_flush_addr, snp_flush_data} == {a, exp_d}, r,
                        32'({snp_flush_addr, snp_flush_data}), 32'({a, exp_d}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({cpu_stall, cpu_resp_valid, bus_req_valid, snp_flush_valid} == 4'b0, "R1",
            32'({cpu_stall, cpu_resp_valid, bus_req_valid, snp_flush_valid}), 32'h0);
        rst = 0;
        @(negedge clk);
        chk({cpu_stall, bus_req_valid} == 2'b0, "R1", 32'({cpu_stall, bus_req_valid}), 32'h0);
        cpu_op(0, 8'h10, 0, memval(8'h10), 1, "R1");     // first access misses (R4)
        cpu_op(0, 8'h10, 0, memval(8'h10), 0, "R2");
        cpu_op(1, 8'h10, 16'h1111, 0, 1, "R6");
        cpu_op(0, 8'h10, 0, 16'h1111, 0, "R2");
        cpu_op(1, 8'h10, 16'h2222, 0, 0, "R3");
        cpu_op(0, 8'h10, 0, 16'h2222, 0, "R3");
        cpu_op(1, 8'h21, 16'h3333, 0, 1, "R5");
        cpu_op(0, 8'h21, 0, 16'h3333, 0, "R5");
        cpu_op(0, 8'h50, 0, memval(8'h50), 2, "R7");
        chk(memval(8'h10) == 16'h2222, "R7", 32'(memval(8'h10)), 32'h2222);
        snoop(2'd0, 8'h21, 1, 16'h3333, "R9");
        cpu_op(1, 8'h21, 16'h4444, 0, 1, "R9");
        snoop(2'd2, 8'h21, 1, 16'h4444, "R10");
        cpu_op(0, 8'h21, 0, 16'h4444, 1, "R10");
        snoop(2'd3, 8'h50, 0, 0, "R11");
        snoop(2'd0, 8'h50, 0, 0, "R11");
        snoop(2'd1, 8'h90, 0, 0, "R11");
        cpu_op(0, 8'h50, 0, memval(8'h50), 0, "R11");
        snoop(2'd1, 8'h50, 0, 0, "R10");
        cpu_op(0, 8'h50, 0, memval(8'h50), 1, "R10");
        cpu_op(0, 8'h33, 0, memval(8'h33), 1, "R4");
        fork
            cpu_op(1, 8'h33, 16'h5555, 0, 1, "R12");
            begin
                @(negedge clk);
                snoop(2'd0, 8'h33, 0, 0, "R6");
                snoop(2'd2, 8'h33, 0, 0, "R12");
            end
        join
        cpu_op(0, 8'h33, 0, 16'h5555, 0, "R12");
        snoop(2'd0, 8'h33, 1, 16'h5555, "R12");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule